// File: doc/BRIEF.md
# Three-Wire Register Serial Master

This block lets on-chip logic read and write 16-bit registers inside an external device that has a three-wire serial port. The three wires are an active-low frame enable, a serial clock and one data line that can be turned around. A requester presents an address, a read/write flag and, for a write, the value. The block then produces the whole serial sequence: the lead-in clock pulses with the enable still high, the frame, the turnaround and read-back for a read, and the trailing pulse after the frame. At the end it pulses `done`, and for a read `rd_data` holds the value that was shifted in.

Each half of the serial clock lasts a programmable number of system clocks, so one design fits devices and board traces of different speeds. The data line leaves the block as a driven value plus an output-enable, with a separate input. The tristate buffer at the pad is outside the block.

Top module: `tws_master`

## Requirements
- R1: After reset and between operations: `sen_n`=1, `sclk`=0, `sdo`=0, `sdo_oe`=1, `busy`=0 and `done`=0. `rd_data` resets to 0.
- R2: A request is taken when `req_valid` is high while `busy` is low. A `req_valid` raised while `busy` is high is ignored and starts no frame.
- R3: After a request is taken, exactly two `sclk` pulses (low phase then high phase) are issued with `sen_n` high. `sen_n` then falls.
- R4: A write frame is 25 `sclk` pulses with `sen_n` low. Bits are sent MSB first, one per pulse: a dummy bit driven 0, a 0 meaning write, `req_addr[6:0]`, then `req_wdata[15:0]`.
- R5: A read frame is a 9-bit header (dummy 0, a 1 meaning read, `req_addr[6:0]`), MSB first. One turnaround pulse follows with `sdo_oe`=1 and `sdo`=0. Then come 16 pulses with `sdo_oe`=0.
- R6: `sdo` only changes while `sclk` is low, and `sen_n` only changes while `sclk` is low.
- R7: During a read, `sdi` is sampled one system clock after each of the 16 data pulses falls and is assembled MSB first. The value appears on `rd_data` in the same cycle as `done`. A write leaves `rd_data` unchanged.
- R8: `sdo_oe` is low only while `sen_n` is low. After a read it returns to 1 a full low phase before `sen_n` rises.
- R9: After `sen_n` rises, exactly one more `sclk` pulse is issued. `done` is then high for exactly one cycle, the cycle after that pulse falls, with `busy` already low.
- R10: Every `sclk` high phase and low phase lasts `half_div` system clocks (a value of 0 acts as 1). `half_div` is captured when the request is taken. `busy` lasts 56·H cycles for a write and 59·H cycles for a read, where H is the effective half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Value to write |
| half_div | input | 8 | System clocks per serial clock half period (0 acts as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Value from the last completed read |
| sen_n | output | 1 | Frame enable, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data driven toward the device |
| sdo_oe | output | 1 | 1 = drive the data pin, 0 = release it |
| sdi | input | 1 | Serial data read back from the pin |

## Verification
The hardest case to reach from the ports is a second request arriving in the middle of a frame together with a change of `half_div`. It must neither start a second frame nor stretch the running one. The stimulus raises `req_valid` with a different address and direction partway through a write, and moves `half_div` at the same time. It then checks three things: the device model saw exactly one frame, that frame carried the original fields, and the busy time still matches the half period captured at the start. Read data comes from a device model that changes `sdi` on each rising clock edge. A value written through the block and read back therefore tests both shift directions together.

// File: rtl/tws_pkg.sv
package tws_pkg;

   // Sequencer states; each pulse state runs low phase then high phase
   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_SHIFT,
      S_TURN,
      S_RDAT,
      S_GAP,
      S_POST
   } seq_state_t;

endpackage

// File: rtl/tws_phase_timer.sv
module tws_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;

   // a half period of zero behaves as one system clock
   assign last = (half == '0) ? '0 : half - 1'b1;
   assign tick = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || tick || !run)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
   parameter int FRAME_W = 25,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               adv,
   input  logic               cap,
   input  logic               sin,
   output logic               msb,
   output logic [DATA_W-1:0]  cap_data
);

   logic [FRAME_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg <= '0;
      else if (load)
         sreg <= load_val;
      else if (adv)
         sreg <= {sreg[FRAME_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cap_data <= '0;
      else if (load)
         cap_data <= '0;
      else if (cap)
         cap_data <= {cap_data[DATA_W-2:0], sin};
   end

   assign msb = sreg[FRAME_W-1];

endmodule

// File: rtl/tws_sequencer.sv
module tws_sequencer
   import tws_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int PRE_N       = 2,
   parameter int POST_N      = 1,
   parameter bit LATE_SAMPLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       start_rd,
   input  logic       tick,
   output seq_state_t st,
   output logic       ph,
   output logic       adv,
   output logic       cap,
   output logic       closing,
   output logic       finish,
   output logic       rd_op
);

   localparam int FRAME_W = 2 + ADDR_W + DATA_W;
   localparam int HDR_W   = 2 + ADDR_W;
   localparam int CNT_W   = $clog2(FRAME_W + PRE_N + POST_N + 1);
   localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_N - 1);
   localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_N - 1);

   logic [CNT_W-1:0] pcnt;
   logic [CNT_W-1:0] shift_last;
   logic             pulse_end;
   logic             done_q;
   logic             rd_q;

   assign pulse_end  = tick && ph;
   assign shift_last = rd_q ? HDR_LAST : WR_LAST;
   assign adv        = pulse_end && (st == S_SHIFT);
   assign closing    = pulse_end && (st == S_POST) && (pcnt == POST_LAST);
   assign finish     = done_q;
   assign rd_op      = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ph     <= 1'b0;
         pcnt   <= '0;
         done_q <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st == S_IDLE) begin
            if (start) begin
               st   <= S_PRE;
               ph   <= 1'b0;
               pcnt <= '0;
               rd_q <= start_rd;
            end
         end else if (tick) begin
            if (!ph) begin
               // the gap is a lone low phase with the line driven again
               if (st == S_GAP) begin
                  st   <= S_POST;
                  pcnt <= '0;
               end else begin
                  ph <= 1'b1;
               end
            end else begin
               ph   <= 1'b0;
               pcnt <= pcnt + 1'b1;
               case (st)
                  S_PRE:
                     if (pcnt == PRE_LAST) begin
                        st   <= S_SHIFT;
                        pcnt <= '0;
                     end
                  S_SHIFT:
                     if (pcnt == shift_last) begin
                        st   <= rd_q ? S_TURN : S_POST;
                        pcnt <= '0;
                     end
                  S_TURN: begin
                     st   <= S_RDAT;
                     pcnt <= '0;
                  end
                  S_RDAT:
                     if (pcnt == DAT_LAST) begin
                        st   <= S_GAP;
                        pcnt <= '0;
                     end
                  S_POST:
                     if (pcnt == POST_LAST) begin
                        st     <= S_IDLE;
                        pcnt   <= '0;
                        done_q <= 1'b1;
                     end
                  default: st <= S_IDLE;
               endcase
            end
         end
      end
   end

   // sample point: one system clock after the fall, or on the falling edge
   generate
      if (LATE_SAMPLE) begin : g_late
         logic cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cap_q <= 1'b0;
            else
               cap_q <= pulse_end && (st == S_RDAT);
         end
         assign cap = cap_q;
      end else begin : g_edge
         assign cap = pulse_end && (st == S_RDAT);
      end
   endgenerate

endmodule

// File: rtl/tws_master.sv
module tws_master
   import tws_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int DIV_W       = 8,
   parameter int PRE_PULSES  = 2,
   parameter int POST_PULSES = 1,
   parameter bit LATE_SAMPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DIV_W-1:0]  half_div,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              sen_n,
   output logic              sclk,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic              sdi
);

   localparam int FRAME_W = 2 + ADDR_W + DATA_W;

   generate
      if (ADDR_W < 1 || DATA_W < 2 || DIV_W < 1) begin : g_bad_width
         $error("tws_master: ADDR_W, DATA_W or DIV_W too small");
      end
      if (PRE_PULSES < 1 || POST_PULSES < 1) begin : g_bad_pulses
         $error("tws_master: lead-in and trailing pulse counts must be at least 1");
      end
   endgenerate

   seq_state_t         st;
   logic               ph;
   logic               tick;
   logic               adv;
   logic               cap;
   logic               closing;
   logic               finish;
   logic               rd_op;
   logic               accept;
   logic               sh_msb;
   logic [DATA_W-1:0]  cap_data;
   logic [DIV_W-1:0]   div_q;
   logic [FRAME_W-1:0] frame_init;

   assign accept     = req_valid && (st == S_IDLE);
   assign frame_init = {1'b0, ~req_write, req_addr,
                        req_write ? req_wdata : {DATA_W{1'b0}}};

   // half period frozen for the whole operation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (accept)
         div_q <= half_div;
   end

   tws_phase_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (busy),
      .half    (div_q),
      .tick    (tick)
   );

   tws_sequencer #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PRE_N       (PRE_PULSES),
      .POST_N      (POST_PULSES),
      .LATE_SAMPLE (LATE_SAMPLE)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .start_rd (~req_write),
      .tick     (tick),
      .st       (st),
      .ph       (ph),
      .adv      (adv),
      .cap      (cap),
      .closing  (closing),
      .finish   (finish),
      .rd_op    (rd_op)
   );

   tws_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame_init),
      .adv      (adv),
      .cap      (cap),
      .sin      (sdi),
      .msb      (sh_msb),
      .cap_data (cap_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (closing && rd_op)
         rd_data <= cap_data;
   end

   assign busy   = (st != S_IDLE);
   assign done   = finish;
   assign sclk   = ph;
   assign sen_n  = !((st == S_SHIFT) || (st == S_TURN) ||
                     (st == S_RDAT)  || (st == S_GAP));
   assign sdo_oe = (st != S_RDAT);
   assign sdo    = (st == S_SHIFT) && sh_msb;

endmodule

// File: rtl/tws_master_chk.sv
module tws_master_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             sen_n,
   input logic             sclk,
   input logic             sdo,
   input logic             sdo_oe,
   input logic [DIV_W-1:0] div_q
);

   logic [DIV_W:0] hi_len;
   logic [DIV_W:0] h_eff;

   assign h_eff = (div_q == '0) ? {{DIV_W{1'b0}}, 1'b1} : {1'b0, div_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_len <= '0;
      else if (sclk)
         hi_len <= hi_len + 1'b1;
      else
         hi_len <= '0;
   end

   p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sen_n && !sclk && !sdo && sdo_oe));

   p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdo));

   p_sen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sen_n) |-> !sclk);

   p_oe_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sen_n);

   p_oe_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sen_n) |-> $past(sdo_oe));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sclk && sen_n));

   p_high_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_len == h_eff));

endmodule

bind tws_master tws_master_chk #(.DIV_W(DIV_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .sen_n  (sen_n),
   .sclk   (sclk),
   .sdo    (sdo),
   .sdo_oe (sdo_oe),
   .div_q  (div_q)
);

// File: tb/tb_tws_master.sv
`timescale 1ns/1ps
module tb_tws_master;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_write;
   logic [6:0]  req_addr;
   logic [15:0] req_wdata;
   logic [7:0]  half_div;
   logic        sdi;
   logic        busy, done, sen_n, sclk, sdo, sdo_oe;
   logic [15:0] rd_data;

   always #2.5 clk = ~clk;

   tws_master dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .half_div(half_div),
      .busy(busy), .done(done), .rd_data(rd_data), .sen_n(sen_n),
      .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
   );

   int checks = 0;
   int errs   = 0;
   int nframes = 0;

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // device model storage and the bench's own expectation of it
   logic [15:0] dev_mem [128];
   logic [15:0] exp_mem [128];
   logic        exp_rd;
   logic [6:0]  exp_addr;
   logic [15:0] exp_wdata;
   logic [15:0] last_rd = '0;

   typedef struct {
      bit          rd;
      logic [15:0] val;
      int          cyc;
   } item_t;
   item_t sbq[$];

   // device model: decodes frames, drives read data on rising sclk
   initial begin
      int npre, nbit, npost;
      logic [24:0] fr;
      logic rdf, turn_ok, rel_ok;
      sdi = 1'b0;
      @(posedge rst_n);
      forever begin
         npre = 0; nbit = 0; npost = 0; fr = '0; rdf = 1'b0;
         turn_ok = 1'b1; rel_ok = 1'b1;
         while (sen_n === 1'b1) begin
            @(posedge sclk or negedge sen_n);
            #1;
            if (sen_n && sclk) npre++;
         end
         while (sen_n === 1'b0) begin
            @(posedge sclk or posedge sen_n);
            #1;
            if (!sen_n) begin
               if (nbit == 1) rdf = sdo;
               if (!rdf || nbit < 9) fr = {fr[23:0], sdo};
               if (rdf && nbit == 9 && (sdo !== 1'b0 || sdo_oe !== 1'b1)) turn_ok = 1'b0;
               if (rdf && nbit >= 10) begin
                  if (sdo_oe !== 1'b0) rel_ok = 1'b0;
                  sdi = dev_mem[fr[6:0]][25-nbit];
               end
               nbit++;
            end
         end
         sdi = 1'b0;
         chk(sdo_oe == 1'b1, "R8 line driven when enable rises", 32'(sdo_oe), 1);
         chk(npre == 2, "R3 lead-in pulses", npre, 2);
         chk(rdf == exp_rd, "R4 read/write bit", 32'(rdf), 32'(exp_rd));
         if (rdf) begin
            chk(nbit == 26, "R5 read pulse count", nbit, 26);
            chk(fr[8:0] == {1'b0, 1'b1, exp_addr}, "R5 read header",
                32'(fr[8:0]), 32'({1'b0, 1'b1, exp_addr}));
            chk(turn_ok, "R5 turnaround pulse", 32'(turn_ok), 1);
            chk(rel_ok, "R5 line released for data", 32'(rel_ok), 1);
         end else begin
            chk(nbit == 25, "R4 write pulse count", nbit, 25);
            chk(fr == {1'b0, 1'b0, exp_addr, exp_wdata}, "R4 write frame",
                32'(fr), 32'({1'b0, 1'b0, exp_addr, exp_wdata}));
            dev_mem[fr[22:16]] = fr[15:0];
         end
         forever begin
            @(posedge sclk or posedge done);
            #1;
            if (done) break;
            npost++;
         end
         chk(npost == 1, "R9 trailing pulses", npost, 1);
         nframes++;
      end
   end

   // scoreboard monitor
   initial begin
      int bcnt;
      item_t it;
      bcnt = 0;
      forever begin
         @(negedge clk);
         if (busy === 1'b1) bcnt++;
         if (done === 1'b1) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R2 completion without request", 1, 0);
            end else begin
               it = sbq.pop_front();
               chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 0);
               if (it.rd)
                  chk(rd_data == it.val, "R7 read data", 32'(rd_data), 32'(it.val));
               else
                  chk(rd_data == it.val, "R7 write keeps rd_data", 32'(rd_data), 32'(it.val));
               chk(bcnt == it.cyc, "R10 busy cycles", bcnt, it.cyc);
            end
            bcnt = 0;
         end
      end
   end

   task automatic issue(input bit wr, input logic [6:0] a, input logic [15:0] d,
                        input int h, input bit disturb);
      item_t it;
      int heff;
      heff = (h == 0) ? 1 : h;
      @(negedge clk);
      exp_rd    = !wr;
      exp_addr  = a;
      exp_wdata = wr ? d : 16'h0;
      half_div  = 8'(h);
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_valid = 1'b1;
      it.rd  = !wr;
      it.val = wr ? last_rd : exp_mem[a];
      it.cyc = (wr ? 56 : 59) * heff;
      sbq.push_back(it);
      if (wr) exp_mem[a] = d;
      else last_rd = exp_mem[a];
      @(negedge clk);
      req_valid = 1'b0;
      if (disturb) begin
         repeat (20) @(negedge clk);
         req_valid = 1'b1;
         req_write = !wr;
         req_addr  = a ^ 7'h55;
         req_wdata = ~d;
         half_div  = 8'(h + 2);
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int f0;
      for (int i = 0; i < 128; i++) begin
         dev_mem[i] = 16'(i * 16'h1357) ^ 16'h5AA5;
         exp_mem[i] = 16'(i * 16'h1357) ^ 16'h5AA5;
      end
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; half_div = 8'd1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sen_n == 1'b1, "R1 reset sen_n", 32'(sen_n), 1);
      chk(sclk == 1'b0, "R1 reset sclk", 32'(sclk), 0);
      chk(sdo == 1'b0, "R1 reset sdo", 32'(sdo), 0);
      chk(sdo_oe == 1'b1, "R1 reset sdo_oe", 32'(sdo_oe), 1);
      chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", 32'({busy, done}), 0);
      chk(rd_data == 16'h0, "R1 reset rd_data", 32'(rd_data), 0);

      issue(1'b0, 7'h05, 16'h0, 1, 1'b0);      // plain read
      issue(1'b1, 7'h05, 16'hBEEF, 1, 1'b0);   // write, rd_data unchanged
      issue(1'b0, 7'h05, 16'h0, 1, 1'b0);      // read back
      issue(1'b1, 7'h7F, 16'h0001, 3, 1'b0);   // top address, slower clock
      issue(1'b0, 7'h7F, 16'h0, 0, 1'b0);      // divider 0 acts as 1
      issue(1'b0, 7'h00, 16'h0, 2, 1'b0);
      issue(1'b1, 7'h00, 16'hFFFF, 2, 1'b0);
      issue(1'b0, 7'h00, 16'h0, 2, 1'b0);

      // R2 and R10: request and divider change during a running frame
      f0 = nframes;
      issue(1'b1, 7'h12, 16'h8421, 3, 1'b1);
      repeat (150) @(negedge clk);
      chk(nframes == f0 + 1, "R2 frames for one request", nframes, f0 + 1);
      chk(busy == 1'b0, "R2 no frame started while busy", 32'(busy), 0);
      issue(1'b0, 7'h12, 16'h0, 4, 1'b0);

      repeat (10) @(negedge clk);
      chk(sen_n && !sclk && !sdo && sdo_oe, "R1 idle lines at end",
          32'({sen_n, sclk, sdo, sdo_oe}), 32'(4'b1001));
      chk(sbq.size() == 0, "R7 every request completed", sbq.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

endmodule